// File: doc/BRIEF.md
# Cache Line Tag Invalidation Unit

This unit executes the "write instruction cache tag" operation of a processor pipeline. It receives a 32-bit instruction word, the value of the first source register and two mode flags: user mode and memory management enabled. When the word is the tag-write operation, the unit either clears one tag entry of the instruction cache through a synchronous write port on the tag RAM, or raises a privileged-instruction fault.

The line to clear is chosen by the first source register value alone. That value is shifted right by the line offset width and then masked to the number of lines. The shift is 4, 5 or 6 bits for lines of 4, 8 or 16 words. The cache byte size and the line length are parameters.

Each accepted operation takes two cycles. In the first cycle `busy` is high and the tag write is issued. In the second cycle a single `done` pulse ends the operation. The operation does not depend on whether the instruction cache is enabled, so the unit has no input for that flag.

Top module: `tagclr_unit`

## Requirements
- R1: An operation is accepted only when `issue_vld` is high, `busy` is low and the word matches all fixed fields. Word bits [31:26] must be 6'b100100, bits [25:21] must be zero and bits [10:0] must be 11'b00001101000. A word that fails any of these bits is ignored: no `busy`, no write and no `done`.
- R2: Word bits [20:11] hold the two register fields. They do not affect recognition or the line index, and they may hold any value.
- R3: The written index is (`ra_val` >> S) mod (CACHE_BYTES / (4*LINE_WORDS)). S is 4, 5 or 6 for LINE_WORDS of 4, 8 or 16.
- R4: A permitted operation raises `tag_we` for exactly the one cycle after acceptance, with `tag_wdata` all zeros.
- R5: If `mmu_on` and `user_mode` are both high at acceptance, `tag_we` stays low. `exc_vld` pulses together with `done`, and `exc_code` becomes 5'b00111.
- R6: If `mmu_on` is low, `user_mode` has no effect and the tag write always happens.
- R7: `busy` is high only in the cycle after acceptance. `done` is high only in the cycle after that, for one cycle.
- R8: A request presented while `busy` is high is dropped. It is not queued.
- R9: Synchronous active-high `rst` clears `busy`, `done`, `tag_we`, `exc_vld` and `exc_code`.
- R10: `exc_code` keeps its last fault value through later permitted operations until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | An instruction word is presented |
| instr | input | 32 | Decoded instruction word |
| ra_val | input | 32 | Value of the first source register |
| user_mode | input | 1 | Processor is in user mode |
| mmu_on | input | 1 | Memory management is configured |
| busy | output | 1 | First cycle of an accepted operation |
| done | output | 1 | Completion pulse, second cycle |
| tag_we | output | 1 | Tag RAM write enable |
| tag_idx | output | $clog2(CACHE_BYTES)-S | Tag RAM line index |
| tag_wdata | output | TAG_W | Tag RAM write data (zero) |
| exc_vld | output | 1 | Privileged-instruction fault pulse |
| exc_code | output | 5 | Exception code register |

## Verification
The `done` pulse of one operation can fall in the same cycle as the acceptance of the next. The bench provokes this by presenting a second request in the cycle where `done` is high. It then checks that the second operation shows `busy` and its own write index in the following cycle, and its own `done` one cycle later. The bench also holds a request high through the `busy` cycle and checks that this request leaves no write behind it.

// File: rtl/tagclr_pkg.sv
package tagclr_pkg;
  localparam logic [5:0]  OPC_MAJOR = 6'b100100;
  localparam logic [10:0] OPC_MINOR = 11'b00001101000;
  localparam logic [4:0]  EXC_PRIV  = 5'b00111;

  // byte offset width of one line: 4 bytes per word
  function automatic int line_shift(input int words);
    return 2 + $clog2(words);
  endfunction

  function automatic int index_width(input int bytes, input int words);
    return $clog2(bytes) - line_shift(words);
  endfunction

  // fixed fields only; register fields [20:11] are don't care
  function automatic logic is_tag_write(input logic [31:0] w);
    return (w[31:26] == OPC_MAJOR) && (w[25:21] == 5'd0) && (w[10:0] == OPC_MINOR);
  endfunction
endpackage

// File: rtl/tagclr_decode.sv
module tagclr_decode (
  input  logic [10:0] hi_bits,
  input  logic [10:0] lo_bits,
  output logic        hit
);
  import tagclr_pkg::*;
  always_comb hit = is_tag_write({hi_bits, 10'd0, lo_bits});
endmodule

// File: rtl/tagclr_index.sv
module tagclr_index #(
  parameter int LINE_WORDS  = 8,
  parameter int CACHE_BYTES = 1024,
  localparam int IDX_W = tagclr_pkg::index_width(CACHE_BYTES, LINE_WORDS)
) (
  input  logic [31:0]      ra,
  output logic [IDX_W-1:0] idx
);
  logic [31:0] shifted;
  generate
    if (LINE_WORDS == 4) begin : g_l4
      assign shifted = ra >> 4;
    end else if (LINE_WORDS == 8) begin : g_l8
      assign shifted = ra >> 5;
    end else begin : g_l16
      assign shifted = ra >> 6;
    end
  endgenerate
  // masking to the line count is a truncation to IDX_W bits
  assign idx = shifted[IDX_W-1:0];
endmodule

// File: rtl/tagclr_seq.sv
module tagclr_seq #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             fault_in,
  input  logic [IDX_W-1:0] idx_in,
  output logic             busy,
  output logic             done,
  output logic             tag_we,
  output logic [IDX_W-1:0] tag_idx,
  output logic             exc_vld,
  output logic [4:0]       exc_code
);
  import tagclr_pkg::*;
  logic fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      tag_we   <= 1'b0;
      tag_idx  <= '0;
      fault_q  <= 1'b0;
      exc_vld  <= 1'b0;
      exc_code <= 5'd0;
    end else begin
      done    <= busy;
      exc_vld <= busy & fault_q;
      if (busy && fault_q) exc_code <= EXC_PRIV;
      if (start) begin
        busy    <= 1'b1;
        tag_we  <= ~fault_in;
        tag_idx <= idx_in;
        fault_q <= fault_in;
      end else begin
        busy    <= 1'b0;
        tag_we  <= 1'b0;
        fault_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tagclr_unit.sv
module tagclr_unit #(
  parameter int LINE_WORDS  = 8,
  parameter int CACHE_BYTES = 1024,
  parameter int TAG_W       = 22,
  localparam int IDX_W = tagclr_pkg::index_width(CACHE_BYTES, LINE_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_vld,
  input  logic [31:0]      instr,
  input  logic [31:0]      ra_val,
  input  logic             user_mode,
  input  logic             mmu_on,
  output logic             busy,
  output logic             done,
  output logic             tag_we,
  output logic [IDX_W-1:0] tag_idx,
  output logic [TAG_W-1:0] tag_wdata,
  output logic             exc_vld,
  output logic [4:0]       exc_code
);
  logic             op_hit;
  logic             accept;
  logic             priv_fault;
  logic [IDX_W-1:0] line_idx;

  tagclr_decode u_dec (
    .hi_bits (instr[31:21]),
    .lo_bits (instr[10:0]),
    .hit     (op_hit)
  );

  tagclr_index #(.LINE_WORDS(LINE_WORDS), .CACHE_BYTES(CACHE_BYTES)) u_idx (
    .ra  (ra_val),
    .idx (line_idx)
  );

  assign accept     = issue_vld & op_hit & ~busy;
  assign priv_fault = mmu_on & user_mode;

  tagclr_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .fault_in (priv_fault),
    .idx_in   (line_idx),
    .busy     (busy),
    .done     (done),
    .tag_we   (tag_we),
    .tag_idx  (tag_idx),
    .exc_vld  (exc_vld),
    .exc_code (exc_code)
  );

  assign tag_wdata = '0;
endmodule

// File: rtl/tagclr_chk.sv
module tagclr_chk (
  input logic       clk,
  input logic       rst,
  input logic       accept,
  input logic       priv_fault,
  input logic       busy,
  input logic       done,
  input logic       tag_we,
  input logic       exc_vld,
  input logic [4:0] exc_code
);
  // R7
  busy_then_done_chk: assert property (@(posedge clk) disable iff (rst) busy |=> done);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R8
  busy_single_chk: assert property (@(posedge clk) disable iff (rst) busy |=> !busy);
  // R4
  write_in_busy_chk: assert property (@(posedge clk) disable iff (rst) tag_we |-> busy);
  // R5
  fault_no_write_chk: assert property (@(posedge clk) disable iff (rst) (accept && priv_fault) |=> !tag_we);
  // R5
  exc_with_done_chk: assert property (@(posedge clk) disable iff (rst) exc_vld |-> (done && exc_code == 5'b00111));
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst) accept |=> busy);
  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (!busy && !done && !tag_we && !exc_vld && exc_code == 5'd0));
endmodule

bind tagclr_unit tagclr_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .accept     (accept),
  .priv_fault (priv_fault),
  .busy       (busy),
  .done       (done),
  .tag_we     (tag_we),
  .exc_vld    (exc_vld),
  .exc_code   (exc_code)
);

// File: tb/sim_tagclr_unit.sv
`timescale 1ns/1ps
module sim_tagclr_unit;
  localparam int LW = 8;
  localparam int CB = 1024;
  localparam int SHIFT_BITS = 5;
  localparam int NLINES = CB / (4 * LW);
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue_vld = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] ra_val = '0;
  logic user_mode = 1'b0;
  logic mmu_on = 1'b0;
  logic busy, done, tag_we, exc_vld;
  logic [IW-1:0] tag_idx;
  logic [21:0] tag_wdata;
  logic [4:0] exc_code;

  int total = 0;
  int bad = 0;
  int exp_code = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tagclr_unit #(.LINE_WORDS(LW), .CACHE_BYTES(CB), .TAG_W(22)) u0 (
    .clk(clk), .rst(rst), .issue_vld(issue_vld), .instr(instr), .ra_val(ra_val),
    .user_mode(user_mode), .mmu_on(mmu_on), .busy(busy), .done(done),
    .tag_we(tag_we), .tag_idx(tag_idx), .tag_wdata(tag_wdata),
    .exc_vld(exc_vld), .exc_code(exc_code)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [9:0] regs);
    return {6'b100100, 5'b00000, regs, 11'b00001101000};
  endfunction

  function automatic int exp_index(input logic [31:0] ra);
    return int'((ra / (32'd1 << SHIFT_BITS)) % NLINES);
  endfunction

  // one full operation, drive at negedge, sample at negedge
  task automatic run_op(input logic [31:0] ra, input logic um, input logic mm, input logic [9:0] regs);
    bit f;
    f = um & mm;
    @(negedge clk);
    issue_vld = 1'b1; instr = word(regs); ra_val = ra; user_mode = um; mmu_on = mm;
    @(negedge clk);
    issue_vld = 1'b0;
    check("R7", "busy cycle1", busy, 1);
    check("R7", "done cycle1", done, 0);
    check(f ? "R5" : (um ? "R6" : "R4"), "tag_we cycle1", tag_we, !f);
    if (!f) check("R3", "tag_idx", tag_idx, exp_index(ra));
    check("R4", "tag_wdata", tag_wdata, 0);
    if (f) exp_code = 7;
    @(negedge clk);
    check("R7", "done cycle2", done, 1);
    check("R7", "busy cycle2", busy, 0);
    check("R4", "tag_we cycle2", tag_we, 0);
    check("R5", "exc_vld", exc_vld, f);
    check("R10", "exc_code", exc_code, exp_code);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9", "busy after reset", busy, 0);
    check("R9", "done after reset", done, 0);
    check("R9", "tag_we after reset", tag_we, 0);
    check("R9", "exc_vld after reset", exc_vld, 0);
    check("R9", "exc_code after reset", exc_code, 0);

    // R3 R6: every line index with several upper-bit patterns, no fault modes
    for (int m = 0; m < 3; m++) begin
      for (int i = 0; i < NLINES; i++) begin
        for (int u = 0; u < 3; u++) begin
          logic [31:0] ra;
          ra = (32'(i) << SHIFT_BITS) | 32'((i * 7 + u) % 32);
          ra = ra | (u == 0 ? 32'h0 : (u == 1 ? 32'hFFFF_FC00 : 32'h5A5A_0000));
          run_op(ra, m[0], m[1] & ~m[0], 10'((i * 37 + u * 101) & 10'h3FF));
        end
      end
    end

    // R2: register fields swept with a fixed address
    for (int r = 0; r < 1024; r += 73) run_op(32'h0000_0260, 1'b0, 1'b1, 10'(r));

    // R5: fault, then R10: code survives a permitted op
    run_op(32'h0000_0040, 1'b1, 1'b1, 10'h155);
    run_op(32'h0000_0080, 1'b0, 1'b1, 10'h0AA);
    run_op(32'h0000_00C0, 1'b1, 1'b0, 10'h000);
    check("R10", "code sticky", exc_code, 7);

    // R1: flip each fixed bit, word must be ignored
    for (int b = 0; b < 32; b++) begin
      if (b >= 11 && b <= 20) continue;
      @(negedge clk);
      issue_vld = 1'b1; instr = word(10'h3FF) ^ (32'd1 << b); ra_val = 32'h20; user_mode = 0; mmu_on = 0;
      @(negedge clk);
      issue_vld = 1'b0;
      check("R1", $sformatf("busy bit%0d", b), busy, 0);
      check("R1", $sformatf("tag_we bit%0d", b), tag_we, 0);
      @(negedge clk);
      check("R1", $sformatf("done bit%0d", b), done, 0);
    end

    // R8: request held through busy is dropped
    @(negedge clk);
    issue_vld = 1'b1; instr = word(10'h0); ra_val = 32'h0000_0100; user_mode = 0; mmu_on = 0;
    @(negedge clk);
    ra_val = 32'h0000_0200;
    check("R8", "first busy", busy, 1);
    check("R8", "first idx", tag_idx, exp_index(32'h100));
    @(negedge clk);
    issue_vld = 1'b0;
    check("R8", "no busy after held req", busy, 0);
    check("R8", "no write after held req", tag_we, 0);
    check("R7", "done of first", done, 1);

    // R7: back-to-back, next accepted in the done cycle
    @(negedge clk);
    issue_vld = 1'b1; ra_val = 32'h0000_0300;
    @(negedge clk);
    ra_val = 32'h0000_03E0;
    check("R7", "A busy", busy, 1);
    @(negedge clk);
    check("R7", "A done overlap", done, 1);
    check("R7", "B not yet busy", busy, 0);
    @(negedge clk);
    issue_vld = 1'b0;
    check("R7", "B busy", busy, 1);
    check("R3", "B idx", tag_idx, exp_index(32'h3E0));
    check("R7", "done gap", done, 0);
    @(negedge clk);
    check("R7", "B done", done, 1);

    // R9: reset clears sticky code
    run_op(32'h0, 1'b1, 1'b1, 10'h0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9", "exc_code cleared", exc_code, 0);
    check("R9", "busy cleared", busy, 0);
    exp_code = 0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule